// File: doc/BRIEF.md
# Effective Address Field Decoder

This block turns the six-bit operand-location field of an instruction word (a three-bit mode and a three-bit register code) into one operand descriptor. Depending on the mode it takes zero, one or two further 16-bit words from an instruction-word stream. The stream uses a valid/ready handshake. The decoder unpacks those words into a displacement, an index-register selection, an absolute address or an immediate value. It does not compute addresses and does not decode opcodes.

A caller presents the mode, register code and operand size together with a one-cycle `start_i` while the block is idle. The block then pulls only the words that mode needs. One cycle after the last word is taken, it raises `done_o` for a single cycle. The descriptor stays on the outputs until the next accepted start. Modes that need no words finish one cycle after the start.

Top module: `ea_field_decoder`

## Requirements
- R1: Modes 0 to 4 take no extension word, report `done_o` one cycle after the accepted start, and give `base_reg_o` equal to the register code. They report tags 0 (data register), 1 (address register), 2 (indirect), 3 (indirect with post-increment) and 4 (indirect with pre-decrement).
- R2: Mode 5 takes one word and reports tag 5. It places that word, sign-extended to 32 bits, on `disp_o`.
- R3: Mode 6 takes one brief word and reports tag 6. In the brief word, bit 15 sets `idx_is_areg_o` (1 means address register), bits 14..12 give `idx_num_o`, and bit 11 sets `idx_long_o` (1 means long). Bits 7..0 are sign-extended to 32 bits on `disp_o`. Bits 10..8 are ignored.
- R4: Mode 7 with register code 2 takes one word and reports tag 9, with a sign-extended 16-bit displacement. Mode 7 with register code 3 takes one brief word, unpacked as in R3, and reports tag 10. Both report `base_reg_o` = 0.
- R5: Mode 7 with register code 0 takes one word and reports tag 7, with that word sign-extended on `value_o`. Register code 1 takes two words and reports tag 8, with `value_o` = {first word, second word}.
- R6: Mode 7 with register code 4 reports tag 11. The size is encoded 0 byte, 1 word, 2 long, 3 none. A byte operand takes one word and gives its low 8 bits zero-extended. A word operand takes one word and gives it zero-extended. A long operand takes two words, first word high.
- R7: Mode 7 with register code 5, 6 or 7, or an immediate with size 3, sets `illegal_o` and reports tag 15. It consumes no word and reports `done_o` one cycle after the start.
- R8: A word is taken only on a cycle with `wd_valid_i` and `wd_ready_o` both high. `wd_ready_o` is low whenever the block is not waiting for a word. Cycles without valid data stretch the transfer. `done_o` rises one cycle after the last word and lasts one cycle.
- R9: `start_i` is ignored while `busy_o` is high. After completion the descriptor outputs hold their values until the next accepted start.
- R10: After reset, `busy_o`, `done_o`, `wd_ready_o`, `illegal_o`, `tag_o`, `disp_o` and `value_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a decode (taken only when idle) |
| ea_mode_i | input | 3 | Mode field |
| ea_reg_i | input | 3 | Register code field |
| op_size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 none |
| wd_valid_i | input | 1 | Stream word available |
| wd_data_i | input | 16 | Stream word |
| wd_ready_o | output | 1 | Decoder takes a stream word this cycle if valid |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | Descriptor complete (one-cycle pulse) |
| illegal_o | output | 1 | Field combination is not allowed |
| tag_o | output | 4 | Decoded mode tag |
| base_reg_o | output | 3 | Base register number |
| idx_is_areg_o | output | 1 | Index register is an address register |
| idx_num_o | output | 3 | Index register number |
| idx_long_o | output | 1 | Index register used as long |
| disp_o | output | 32 | Sign-extended displacement |
| value_o | output | 32 | Absolute address or immediate value |

## Verification
The assertions assume that `start_i` is a single-cycle request and that the mode, register code and size are steady in the cycle it is taken. They also assume the stream presents a word only as fresh data on the handshake cycle. The stimulus drives every input at the falling edge. It raises `start_i` only for one cycle, except in the deliberate attempt to start during a fetch. It holds `wd_valid_i` high only while it is offering a word, except in the idle-probing steps that check that nothing is taken.

// File: rtl/ea_pkg.sv
package ea_pkg;

   localparam int EA_TAG_W   = 4;
   localparam int EA_FIELD_W = 3;

   // Brief index word layout (decoded positions)
   localparam int BX_TYPE_BIT = 15;
   localparam int BX_NUM_HI   = 14;
   localparam int BX_NUM_LO   = 12;
   localparam int BX_LONG_BIT = 11;
   localparam int BX_DISP_W   = 8;

   typedef enum logic [EA_TAG_W-1:0] {
      TAG_DREG      = 4'd0,
      TAG_AREG      = 4'd1,
      TAG_IND       = 4'd2,
      TAG_POSTINC   = 4'd3,
      TAG_PREDEC    = 4'd4,
      TAG_DISP16    = 4'd5,
      TAG_INDEX     = 4'd6,
      TAG_ABS_SHORT = 4'd7,
      TAG_ABS_LONG  = 4'd8,
      TAG_PC_DISP   = 4'd9,
      TAG_PC_INDEX  = 4'd10,
      TAG_IMM       = 4'd11,
      TAG_BAD       = 4'd15
   } ea_tag_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_NONE = 2'd3
   } op_size_e;

endpackage

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
   import ea_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic [EA_FIELD_W-1:0] mode_i,
   input  logic [EA_FIELD_W-1:0] rsel_i,
   input  op_size_e              size_i,
   output ea_tag_e               tag_o,
   output logic [CNT_W-1:0]      need_o,
   output logic                  illegal_o
);

   localparam logic [CNT_W-1:0] NEED0 = CNT_W'(0);
   localparam logic [CNT_W-1:0] NEED1 = CNT_W'(1);
   localparam logic [CNT_W-1:0] NEED2 = CNT_W'(2);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ea_mode_classify: CNT_W must hold a count of two");
   end

   always_comb begin
      tag_o     = TAG_BAD;
      need_o    = NEED0;
      illegal_o = 1'b0;
      unique case (mode_i)
         3'd0: tag_o = TAG_DREG;
         3'd1: tag_o = TAG_AREG;
         3'd2: tag_o = TAG_IND;
         3'd3: tag_o = TAG_POSTINC;
         3'd4: tag_o = TAG_PREDEC;
         3'd5: begin
            tag_o  = TAG_DISP16;
            need_o = NEED1;
         end
         3'd6: begin
            tag_o  = TAG_INDEX;
            need_o = NEED1;
         end
         default: begin
            unique case (rsel_i)
               3'd0: begin
                  tag_o  = TAG_ABS_SHORT;
                  need_o = NEED1;
               end
               3'd1: begin
                  tag_o  = TAG_ABS_LONG;
                  need_o = NEED2;
               end
               3'd2: begin
                  tag_o  = TAG_PC_DISP;
                  need_o = NEED1;
               end
               3'd3: begin
                  tag_o  = TAG_PC_INDEX;
                  need_o = NEED1;
               end
               3'd4: begin
                  if (size_i == SZ_NONE) begin
                     tag_o     = TAG_BAD;
                     illegal_o = 1'b1;
                  end else begin
                     tag_o  = TAG_IMM;
                     need_o = (size_i == SZ_LONG) ? NEED2 : NEED1;
                  end
               end
               default: begin
                  tag_o     = TAG_BAD;
                  illegal_o = 1'b1;
               end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/ea_ext_collect.sv
module ea_ext_collect #(
   parameter int WORD_W  = 16,
   parameter int MAX_EXT = 2,
   parameter int CNT_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [CNT_W-1:0]          need_i,
   input  logic                      wd_valid_i,
   input  logic [WORD_W-1:0]         wd_data_i,
   output logic                      wd_ready_o,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [MAX_EXT*WORD_W-1:0] words_o
);

   typedef enum logic [1:0] {
      C_IDLE   = 2'd0,
      C_FETCH  = 2'd1,
      C_REPORT = 2'd2
   } col_state_e;

   if ((1 << CNT_W) <= MAX_EXT) begin : g_bad_width
      $error("ea_ext_collect: CNT_W too narrow for MAX_EXT");
   end

   col_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] need_q;
   logic             take;
   logic             accept;
   logic [CNT_W-1:0] cnt_nxt;

   assign accept     = start_i && (state_q == C_IDLE);
   assign wd_ready_o = (state_q == C_FETCH);
   assign take       = wd_valid_i && wd_ready_o;
   assign busy_o     = (state_q != C_IDLE);
   assign done_o     = (state_q == C_REPORT);
   assign cnt_nxt    = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= C_IDLE;
         cnt_q   <= '0;
         need_q  <= '0;
      end else begin
         unique case (state_q)
            C_IDLE: begin
               if (accept) begin
                  need_q  <= need_i;
                  cnt_q   <= '0;
                  state_q <= (need_i == '0) ? C_REPORT : C_FETCH;
               end
            end
            C_FETCH: begin
               if (take) begin
                  cnt_q <= cnt_nxt;
                  if (cnt_nxt == need_q) begin
                     state_q <= C_REPORT;
                  end
               end
            end
            default: state_q <= C_IDLE;
         endcase
      end
   end

   // One storage slot per possible extension word
   for (genvar s = 0; s < MAX_EXT; s++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (accept) begin
            slot_q <= '0;
         end else if (take && (cnt_q == CNT_W'(s))) begin
            slot_q <= wd_data_i;
         end
      end
      assign words_o[s*WORD_W +: WORD_W] = slot_q;
   end

   AST_TAKE_WITHIN_NEED: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cnt_q < need_q));                                          // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                 // R8
   AST_NO_TAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !wd_ready_o);                                             // R8

endmodule

// File: rtl/ea_operand_build.sv
module ea_operand_build
   import ea_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 32,
   parameter int MAX_EXT = 2
) (
   input  ea_tag_e                   tag_i,
   input  logic [EA_FIELD_W-1:0]     rsel_i,
   input  op_size_e                  size_i,
   input  logic [MAX_EXT*WORD_W-1:0] words_i,
   output logic [EA_FIELD_W-1:0]     base_reg_o,
   output logic                      idx_is_areg_o,
   output logic [EA_FIELD_W-1:0]     idx_num_o,
   output logic                      idx_long_o,
   output logic [ADDR_W-1:0]         disp_o,
   output logic [ADDR_W-1:0]         value_o
);

   localparam int EXT16_W = ADDR_W - WORD_W;
   localparam int EXT8_W  = ADDR_W - BX_DISP_W;
   localparam int BYTE_PAD = ADDR_W - 8;

   if (ADDR_W != 2 * WORD_W) begin : g_bad_addr
      $error("ea_operand_build: ADDR_W must be twice WORD_W");
   end
   if (MAX_EXT < 2) begin : g_bad_ext
      $error("ea_operand_build: MAX_EXT must be at least two");
   end
   if (WORD_W < 16) begin : g_bad_word
      $error("ea_operand_build: WORD_W must cover the brief word layout");
   end

   logic [WORD_W-1:0] w0;
   logic [WORD_W-1:0] w1;
   logic [ADDR_W-1:0] sext_w0;
   logic [ADDR_W-1:0] sext_brief;
   logic [ADDR_W-1:0] pair;
   logic              brief_mode;
   logic              d16_mode;

   assign w0         = words_i[0 +: WORD_W];
   assign w1         = words_i[WORD_W +: WORD_W];
   assign sext_w0    = {{EXT16_W{w0[WORD_W-1]}}, w0};
   assign sext_brief = {{EXT8_W{w0[BX_DISP_W-1]}}, w0[BX_DISP_W-1:0]};
   assign pair       = {w0, w1};
   assign brief_mode = (tag_i == TAG_INDEX) || (tag_i == TAG_PC_INDEX);
   assign d16_mode   = (tag_i == TAG_DISP16) || (tag_i == TAG_PC_DISP);

   always_comb begin
      base_reg_o = '0;
      if (tag_i <= TAG_INDEX) begin
         base_reg_o = rsel_i;
      end
   end

   always_comb begin
      idx_is_areg_o = 1'b0;
      idx_num_o     = '0;
      idx_long_o    = 1'b0;
      if (brief_mode) begin
         idx_is_areg_o = w0[BX_TYPE_BIT];
         idx_num_o     = w0[BX_NUM_HI:BX_NUM_LO];
         idx_long_o    = w0[BX_LONG_BIT];
      end
   end

   always_comb begin
      disp_o = '0;
      if (d16_mode) begin
         disp_o = sext_w0;
      end else if (brief_mode) begin
         disp_o = sext_brief;
      end
   end

   always_comb begin
      value_o = '0;
      unique case (tag_i)
         TAG_ABS_SHORT: value_o = sext_w0;
         TAG_ABS_LONG:  value_o = pair;
         TAG_IMM: begin
            unique case (size_i)
               SZ_BYTE: value_o = {{BYTE_PAD{1'b0}}, w0[7:0]};
               SZ_WORD: value_o = {{EXT16_W{1'b0}}, w0};
               SZ_LONG: value_o = pair;
               default: value_o = '0;
            endcase
         end
         default: value_o = '0;
      endcase
   end

endmodule

// File: rtl/ea_field_decoder.sv
module ea_field_decoder
   import ea_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 32,
   parameter int MAX_EXT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    ea_mode_i,
   input  logic [2:0]    ea_reg_i,
   input  logic [1:0]    op_size_i,
   input  logic          wd_valid_i,
   input  logic [15:0]   wd_data_i,
   output logic          wd_ready_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          illegal_o,
   output logic [3:0]    tag_o,
   output logic [2:0]    base_reg_o,
   output logic          idx_is_areg_o,
   output logic [2:0]    idx_num_o,
   output logic          idx_long_o,
   output logic [31:0]   disp_o,
   output logic [31:0]   value_o
);

   localparam int CNT_W = $clog2(MAX_EXT + 1);

   if (WORD_W != 16 || ADDR_W != 32) begin : g_bad_ports
      $error("ea_field_decoder: port widths fix WORD_W=16 and ADDR_W=32");
   end

   ea_tag_e                   cls_tag;
   logic [CNT_W-1:0]          cls_need;
   logic                      cls_illegal;
   logic                      start_acc;
   logic [MAX_EXT*WORD_W-1:0] words;

   ea_tag_e                   tag_q;
   logic [EA_FIELD_W-1:0]     reg_q;
   op_size_e                  size_q;
   logic                      ill_q;

   assign start_acc = start_i && !busy_o;

   ea_mode_classify #(.CNT_W(CNT_W)) i_classify (
      .mode_i    (ea_mode_i),
      .rsel_i    (ea_reg_i),
      .size_i    (op_size_e'(op_size_i)),
      .tag_o     (cls_tag),
      .need_o    (cls_need),
      .illegal_o (cls_illegal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= TAG_DREG;
         reg_q  <= '0;
         size_q <= SZ_BYTE;
         ill_q  <= 1'b0;
      end else if (start_acc) begin
         tag_q  <= cls_tag;
         reg_q  <= ea_reg_i;
         size_q <= op_size_e'(op_size_i);
         ill_q  <= cls_illegal;
      end
   end

   ea_ext_collect #(
      .WORD_W  (WORD_W),
      .MAX_EXT (MAX_EXT),
      .CNT_W   (CNT_W)
   ) i_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_acc),
      .need_i     (cls_need),
      .wd_valid_i (wd_valid_i),
      .wd_data_i  (wd_data_i),
      .wd_ready_o (wd_ready_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .words_o    (words)
   );

   ea_operand_build #(
      .WORD_W  (WORD_W),
      .ADDR_W  (ADDR_W),
      .MAX_EXT (MAX_EXT)
   ) i_build (
      .tag_i         (tag_q),
      .rsel_i        (reg_q),
      .size_i        (size_q),
      .words_i       (words),
      .base_reg_o    (base_reg_o),
      .idx_is_areg_o (idx_is_areg_o),
      .idx_num_o     (idx_num_o),
      .idx_long_o    (idx_long_o),
      .disp_o        (disp_o),
      .value_o       (value_o)
   );

   assign tag_o     = tag_q;
   assign illegal_o = ill_q;

   AST_ILLEGAL_NO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && illegal_o) |-> $past(start_acc));                         // R7
   AST_DISP16_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (tag_q == TAG_DISP16)) |-> (disp_o[31:16] == {16{disp_o[15]}})); // R2
   AST_BRIEF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (tag_q == TAG_INDEX || tag_q == TAG_PC_INDEX))
         |-> (disp_o[31:8] == {24{disp_o[7]}}));                           // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(disp_o) && $stable(value_o) && $stable(tag_o))); // R9
   AST_REG_ZERO_MODE7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && tag_q >= TAG_ABS_SHORT) |-> (base_reg_o == 3'd0));         // R4

endmodule

// File: tb/test_ea_field_decoder.sv
module test_ea_field_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [2:0]  ea_mode_i;
   logic [2:0]  ea_reg_i;
   logic [1:0]  op_size_i;
   logic        wd_valid_i;
   logic [15:0] wd_data_i;
   logic        wd_ready_o, busy_o, done_o, illegal_o;
   logic [3:0]  tag_o;
   logic [2:0]  base_reg_o, idx_num_o;
   logic        idx_is_areg_o, idx_long_o;
   logic [31:0] disp_o, value_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ea_field_decoder i_ea_field_decoder (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_mode_i(ea_mode_i),
      .ea_reg_i(ea_reg_i), .op_size_i(op_size_i), .wd_valid_i(wd_valid_i),
      .wd_data_i(wd_data_i), .wd_ready_o(wd_ready_o), .busy_o(busy_o),
      .done_o(done_o), .illegal_o(illegal_o), .tag_o(tag_o),
      .base_reg_o(base_reg_o), .idx_is_areg_o(idx_is_areg_o),
      .idx_num_o(idx_num_o), .idx_long_o(idx_long_o), .disp_o(disp_o),
      .value_o(value_o)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // Issue one decode, feed nw words, check the handshake and done timing
   task automatic do_op(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                        input int nw, input logic [15:0] w0, input logic [15:0] w1,
                        input bit stall);
      @(negedge clk);
      for (int k = 0; k < 8 && busy_o; k++) @(negedge clk);
      ea_mode_i = m; ea_reg_i = r; op_size_i = sz; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < nw; k++) begin
         if (stall) begin
            wd_valid_i = 1'b0;
            @(negedge clk);
         end
         wd_valid_i = 1'b1;
         wd_data_i  = (k == 0) ? w0 : w1;
         chk("R8 ready while fetching", {31'd0, wd_ready_o}, 32'd1);
         @(negedge clk);
      end
      wd_valid_i = 1'b0;
      chk("R8 done after last word", {31'd0, done_o}, 32'd1);
   endtask

   task automatic t_reset;
      chk("R10 busy", {31'd0, busy_o}, 32'd0);
      chk("R10 done", {31'd0, done_o}, 32'd0);
      chk("R10 ready", {31'd0, wd_ready_o}, 32'd0);
      chk("R10 illegal", {31'd0, illegal_o}, 32'd0);
      chk("R10 tag", {28'd0, tag_o}, 32'd0);
      chk("R10 disp", disp_o, 32'd0);
      chk("R10 value", value_o, 32'd0);
   endtask

   task automatic t_plain_modes;
      do_op(3'd0, 3'd5, 2'd2, 0, 16'h0, 16'h0, 0);
      chk("R1 tag dreg", {28'd0, tag_o}, 32'd0);
      chk("R1 base dreg", {29'd0, base_reg_o}, 32'd5);
      do_op(3'd1, 3'd6, 2'd1, 0, 16'h0, 16'h0, 0);
      chk("R1 tag areg", {28'd0, tag_o}, 32'd1);
      do_op(3'd3, 3'd2, 2'd1, 0, 16'h0, 16'h0, 0);
      chk("R1 tag postinc", {28'd0, tag_o}, 32'd3);
      chk("R1 base postinc", {29'd0, base_reg_o}, 32'd2);
      do_op(3'd4, 3'd7, 2'd0, 0, 16'h0, 16'h0, 0);
      chk("R1 tag predec", {28'd0, tag_o}, 32'd4);
      chk("R1 base predec", {29'd0, base_reg_o}, 32'd7);
   endtask

   task automatic t_disp16;
      do_op(3'd5, 3'd1, 2'd1, 1, 16'hFFFE, 16'h0, 1);
      chk("R2 tag", {28'd0, tag_o}, 32'd5);
      chk("R2 base", {29'd0, base_reg_o}, 32'd1);
      chk("R2 negative disp", disp_o, 32'hFFFF_FFFE);
      do_op(3'd5, 3'd0, 2'd1, 1, 16'h1234, 16'h0, 0);
      chk("R2 positive disp", disp_o, 32'h0000_1234);
   endtask

   task automatic t_brief;
      do_op(3'd6, 3'd3, 2'd1, 1, 16'hA880, 16'h0, 0);
      chk("R3 tag", {28'd0, tag_o}, 32'd6);
      chk("R3 base", {29'd0, base_reg_o}, 32'd3);
      chk("R3 type areg", {31'd0, idx_is_areg_o}, 32'd1);
      chk("R3 num", {29'd0, idx_num_o}, 32'd2);
      chk("R3 long", {31'd0, idx_long_o}, 32'd1);
      chk("R3 negative disp", disp_o, 32'hFFFF_FF80);
      do_op(3'd6, 3'd0, 2'd1, 1, 16'h7705, 16'h0, 1);
      chk("R3 type dreg", {31'd0, idx_is_areg_o}, 32'd0);
      chk("R3 num seven", {29'd0, idx_num_o}, 32'd7);
      chk("R3 word index", {31'd0, idx_long_o}, 32'd0);
      chk("R3 positive disp, bits 10..8 ignored", disp_o, 32'h0000_0005);
   endtask

   task automatic t_pc_rel;
      do_op(3'd7, 3'd2, 2'd1, 1, 16'h8000, 16'h0, 0);
      chk("R4 pc disp tag", {28'd0, tag_o}, 32'd9);
      chk("R4 pc disp", disp_o, 32'hFFFF_8000);
      chk("R4 pc base zero", {29'd0, base_reg_o}, 32'd0);
      do_op(3'd7, 3'd3, 2'd1, 1, 16'h3812, 16'h0, 0);
      chk("R4 pc index tag", {28'd0, tag_o}, 32'd10);
      chk("R4 pc index num", {29'd0, idx_num_o}, 32'd3);
      chk("R4 pc index long", {31'd0, idx_long_o}, 32'd1);
      chk("R4 pc index disp", disp_o, 32'h0000_0012);
   endtask

   task automatic t_absolute;
      do_op(3'd7, 3'd0, 2'd1, 1, 16'h9000, 16'h0, 0);
      chk("R5 short tag", {28'd0, tag_o}, 32'd7);
      chk("R5 short value", value_o, 32'hFFFF_9000);
      do_op(3'd7, 3'd1, 2'd1, 2, 16'h1234, 16'h5678, 1);
      chk("R5 long tag", {28'd0, tag_o}, 32'd8);
      chk("R5 long value", value_o, 32'h1234_5678);
   endtask

   task automatic t_immediate;
      do_op(3'd7, 3'd4, 2'd0, 1, 16'hABCD, 16'h0, 0);
      chk("R6 tag", {28'd0, tag_o}, 32'd11);
      chk("R6 byte", value_o, 32'h0000_00CD);
      do_op(3'd7, 3'd4, 2'd1, 1, 16'h8001, 16'h0, 0);
      chk("R6 word", value_o, 32'h0000_8001);
      do_op(3'd7, 3'd4, 2'd2, 2, 16'hDEAD, 16'hBEEF, 0);
      chk("R6 long", value_o, 32'hDEAD_BEEF);
   endtask

   task automatic t_illegal;
      do_op(3'd7, 3'd5, 2'd1, 0, 16'h0, 16'h0, 0);
      chk("R7 reg5 flag", {31'd0, illegal_o}, 32'd1);
      chk("R7 reg5 tag", {28'd0, tag_o}, 32'd15);
      chk("R7 no fetch", {31'd0, wd_ready_o}, 32'd0);
      do_op(3'd7, 3'd7, 2'd2, 0, 16'h0, 16'h0, 0);
      chk("R7 reg7 flag", {31'd0, illegal_o}, 32'd1);
      do_op(3'd7, 3'd4, 2'd3, 0, 16'h0, 16'h0, 0);
      chk("R7 sizeless immediate flag", {31'd0, illegal_o}, 32'd1);
      chk("R7 sizeless immediate tag", {28'd0, tag_o}, 32'd15);
      do_op(3'd7, 3'd0, 2'd1, 1, 16'h0042, 16'h0, 0);
      chk("R7 flag clears on legal op", {31'd0, illegal_o}, 32'd0);
      chk("R7 next word intact", value_o, 32'h0000_0042);
   endtask

   task automatic t_start_while_busy;
      @(negedge clk);
      ea_mode_i = 3'd5; ea_reg_i = 3'd2; op_size_i = 2'd1; start_i = 1'b1;
      @(negedge clk);
      ea_mode_i = 3'd0; ea_reg_i = 3'd1; start_i = 1'b1;
      wd_valid_i = 1'b1; wd_data_i = 16'h0100;
      @(negedge clk);
      start_i = 1'b0; wd_valid_i = 1'b0;
      chk("R9 done despite second start", {31'd0, done_o}, 32'd1);
      chk("R9 tag kept", {28'd0, tag_o}, 32'd5);
      chk("R9 base kept", {29'd0, base_reg_o}, 32'd2);
      chk("R9 disp", disp_o, 32'h0000_0100);
   endtask

   task automatic t_hold_idle;
      do_op(3'd7, 3'd1, 2'd1, 2, 16'hCAFE, 16'hF00D, 0);
      @(negedge clk);
      chk("R8 done one cycle", {31'd0, done_o}, 32'd0);
      for (int k = 0; k < 3; k++) begin
         wd_valid_i = 1'b1; wd_data_i = 16'h1111 * (k + 1);
         chk("R8 no ready when idle", {31'd0, wd_ready_o}, 32'd0);
         @(negedge clk);
      end
      wd_valid_i = 1'b0;
      chk("R9 value held", value_o, 32'hCAFE_F00D);
      chk("R9 tag held", {28'd0, tag_o}, 32'd8);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      bad++; total++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; ea_mode_i = '0; ea_reg_i = '0;
      op_size_i = '0; wd_valid_i = 1'b0; wd_data_i = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_plain_modes;
      t_disp16;
      t_brief;
      t_pc_rel;
      t_absolute;
      t_immediate;
      t_illegal;
      t_start_while_busy;
      t_hold_idle;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule